// File: doc/BRIEF.md
# MDIO Management Controller

This block runs Clause-22 management frames towards external PHYs and switches. Software reaches it through a plain 32-bit register bus with single-cycle writes and combinational read-back. The block drives the management clock, the serial data output and its output enable, and it samples the serial data input. Software selects a clock divider code, loads a PHY address and a register number, and then starts a frame. A write frame starts when software writes the write-data register. A read frame starts when software writes 1 to the command bit.

While a frame runs, software polls a busy flag. When a read ends, software collects the 16 returned bits from the status register. A separate flag marks read data as not yet valid from the start of a read until its last bit has been captured. A soft-reset bit in the configuration register aborts any frame in progress and blocks new frames while it stays set.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The register map is as follows, and every bit not listed reads 0. 0x20 is configuration: bit 31 is the soft reset and bits 3:0 are the divider code. 0x24 is the command register, with bit 0 the read request. 0x28 is the address register: PHY address in bits 12:8, register number in bits 4:0. 0x2C is write data in bits 15:0. 0x30 is read data in bits 15:0. 0x34 is the indicator register: bit 0 busy, bit 2 read data invalid. All registers reset to 0.
- R2: A write to 0x2C while idle starts a frame of 64 bit times. The frame is 32 ones, then 01, then opcode 01, then the 5-bit PHY address, then the 5-bit register number, then 10, then the 16 data bits MSB first. The output enable stays high for the whole frame.
- R3: A write to 0x24 with bit 0 = 1 while idle starts a read frame. The frame is 32 ones, then 01, then opcode 10, then the PHY address, then the register number. The output enable is low for the two turnaround bits and the 16 data bits. The data bits are sampled, MSB first, on the rising edges of the management clock, and they appear at 0x30 when the frame ends.
- R4: The management clock is low for the first half of every bit time and high for the second half. The data output changes only at a falling clock edge or at the start of a frame.
- R5: Divider codes 4, 5, 7 and 9 give half periods of 10, 14, 20 and 28 system clocks. Every other code gives 28. The code is taken when a frame starts.
- R6: Busy reads 1 from the clock edge that accepts a start. It clears 128 half periods later, and the last rising edge of the management clock falls inside that window.
- R7: The invalid flag sets when a read starts and clears when that read completes. A write frame does not set it.
- R8: While busy, writes to 0x2C and read requests are ignored. The write-data register keeps its value, no new frame is queued, and the invalid flag stays unchanged.
- R9: The address fields are captured when a frame starts. Writing 0x28 during a frame changes the register but not the frame on the wire.
- R10: Writing 0x20 with bit 31 set aborts a running frame in the same clock edge. On the next cycle busy and invalid read 0, the management clock is low and the output is released. While bit 31 stays set, starts are ignored and 0x2C keeps its value.
- R11: While idle, the management clock is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read-back of the addressed register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data output |
| mdio_oe | output | 1 | Output enable for the serial data pad |
| mdio_i | input | 1 | Serial data input from the pad |

## Verification
A register write takes effect at the clock edge that samples it. Busy, invalid and the first bit of the frame are therefore visible one cycle later, and register read-back is valid within the same cycle. Within a frame that starts at edge S with half period H, the management clock after edge S+e equals (e/H) mod 2, and the bit being driven is e/(2H). Busy and the read data change together at edge S+128H. The bench model applies these formulas every clock and compares them about 2 ns after each falling system-clock edge. The directed duration checks count the falling edges on which busy reads 1, and each expected count subtracts any cycle spent on a register read before counting begins.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   localparam int PHY_W  = 5;
   localparam int REG_W  = 5;
   localparam int DATA_W = 16;

   // register byte offsets; software decodes these
   localparam int OFS_CFG  = 'h20;
   localparam int OFS_CMD  = 'h24;
   localparam int OFS_ADR  = 'h28;
   localparam int OFS_WDAT = 'h2C;
   localparam int OFS_RDAT = 'h30;
   localparam int OFS_IND  = 'h34;

   // divider code to half-period (system clocks)
   localparam int CODE_A = 4;
   localparam int CODE_B = 5;
   localparam int CODE_C = 7;
   localparam int CODE_D = 9;
   localparam int HALF_A = 10;
   localparam int HALF_B = 14;
   localparam int HALF_C = 20;
   localparam int HALF_D = 28;
   localparam int HALF_DFLT = 28;
   localparam int HALF_MAX  = 28;

   typedef struct packed {
      logic              rd;
      logic [PHY_W-1:0]  phy;
      logic [REG_W-1:0]  regn;
      logic [DATA_W-1:0] wdata;
   } mdio_req_t;

endpackage

// File: rtl/mdio_mgmt_divsel.sv
module mdio_mgmt_divsel
   import mdio_mgmt_pkg::*;
#(
   parameter int CODE_W     = 4,
   parameter int CNT_W      = 5,
   parameter int FIXED_HALF = 0
) (
   input  logic [CODE_W-1:0] code,
   output logic [CNT_W-1:0]  half_lim
);

   generate
      if (FIXED_HALF == 0) begin : g_table
         always_comb begin
            case (code)
               CODE_W'(CODE_A): half_lim = CNT_W'(HALF_A);
               CODE_W'(CODE_B): half_lim = CNT_W'(HALF_B);
               CODE_W'(CODE_C): half_lim = CNT_W'(HALF_C);
               CODE_W'(CODE_D): half_lim = CNT_W'(HALF_D);
               default:         half_lim = CNT_W'(HALF_DFLT);
            endcase
         end
      end else begin : g_fixed
         logic unused_code;
         assign unused_code = ^code;
         assign half_lim    = CNT_W'(FIXED_HALF);
      end
   endgenerate

endmodule

// File: rtl/mdio_mgmt_frame.sv
module mdio_mgmt_frame
   import mdio_mgmt_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int CNT_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  mdio_req_t        req,
   input  logic [CNT_W-1:0] half_lim,
   input  logic             abort,
   input  logic             mdio_i,
   output logic             busy,
   output logic             mdc,
   output logic             mdio_o,
   output logic             mdio_oe,
   output logic             rd_fin,
   output logic [DATA_W-1:0] rd_data
);

   localparam int FRAME_W    = PRE_LEN + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
   localparam int HDR_W      = FRAME_W - DATA_W - 2;
   localparam int DATA_FIRST = FRAME_W - DATA_W;
   localparam int IDX_W      = $clog2(FRAME_W);

   logic [FRAME_W-1:0] shreg;
   logic [FRAME_W-1:0] built;
   logic [CNT_W-1:0]   half_q;
   logic [CNT_W-1:0]   half_cnt;
   logic               phase;
   logic [IDX_W-1:0]   bit_idx;
   logic               op_rd;
   logic [DATA_W-1:0]  rx_q;
   logic               half_end;
   logic               last_bit;
   logic               next_oe;

   always_comb begin
      built = {{PRE_LEN{1'b1}}, 2'b01,
               (req.rd ? 2'b10 : 2'b01),
               req.phy, req.regn,
               (req.rd ? 2'b11 : 2'b10),
               (req.rd ? {DATA_W{1'b1}} : req.wdata)};
   end

   assign half_end = (half_cnt == half_q - CNT_W'(1));
   assign last_bit = (bit_idx == IDX_W'(FRAME_W - 1));
   assign next_oe  = !op_rd || ((int'(bit_idx) + 1) < HDR_W);
   assign rd_fin   = busy && !abort && op_rd && phase && half_end && last_bit;
   assign rd_data  = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         mdc      <= 1'b0;
         mdio_o   <= 1'b0;
         mdio_oe  <= 1'b0;
         half_q   <= '0;
         half_cnt <= '0;
         phase    <= 1'b0;
         bit_idx  <= '0;
         op_rd    <= 1'b0;
         shreg    <= '0;
         rx_q     <= '0;
      end else if (abort) begin
         busy     <= 1'b0;
         mdc      <= 1'b0;
         mdio_oe  <= 1'b0;
         half_cnt <= '0;
         phase    <= 1'b0;
         bit_idx  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy     <= 1'b1;
            mdc      <= 1'b0;
            mdio_o   <= built[FRAME_W-1];
            mdio_oe  <= 1'b1;
            half_q   <= half_lim;
            half_cnt <= '0;
            phase    <= 1'b0;
            bit_idx  <= '0;
            op_rd    <= req.rd;
            shreg    <= built;
         end
      end else if (half_end) begin
         half_cnt <= '0;
         if (!phase) begin
            phase <= 1'b1;
            mdc   <= 1'b1;
            if (op_rd && (bit_idx >= IDX_W'(DATA_FIRST)))
               rx_q <= {rx_q[DATA_W-2:0], mdio_i};
         end else begin
            phase <= 1'b0;
            mdc   <= 1'b0;
            if (last_bit) begin
               busy    <= 1'b0;
               mdio_oe <= 1'b0;
            end else begin
               bit_idx <= bit_idx + IDX_W'(1);
               shreg   <= {shreg[FRAME_W-2:0], 1'b0};
               mdio_o  <= shreg[FRAME_W-2];
               mdio_oe <= next_oe;
            end
         end
      end else begin
         half_cnt <= half_cnt + CNT_W'(1);
      end
   end

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdio_oe && !mdc));

   assert_out_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

   assert_release_ta_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_rd && (bit_idx >= IDX_W'(HDR_W))) |-> !mdio_oe);

   assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy && !mdc && !mdio_oe));

   assert_half_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (half_q != '0));

endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
   import mdio_mgmt_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              busy,
   input  logic              rd_fin,
   input  logic [DATA_W-1:0] rd_data,
   output logic              start,
   output mdio_req_t         req,
   output logic              abort,
   output logic [CODE_W-1:0] code
);

   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
   localparam logic [ADDR_W-1:0] A_ADR  = ADDR_W'(OFS_ADR);
   localparam logic [ADDR_W-1:0] A_WDAT = ADDR_W'(OFS_WDAT);
   localparam logic [ADDR_W-1:0] A_RDAT = ADDR_W'(OFS_RDAT);
   localparam logic [ADDR_W-1:0] A_IND  = ADDR_W'(OFS_IND);

   logic              soft_q;
   logic [CODE_W-1:0] code_q;
   logic              cmd_q;
   logic [PHY_W-1:0]  phy_q;
   logic [REG_W-1:0]  regn_q;
   logic [DATA_W-1:0] wdat_q;
   logic [DATA_W-1:0] rdat_q;
   logic              inv_q;
   logic              wr_cfg, wr_cmd, wr_adr, wr_wdat;
   logic              rd_go, wr_go;
   logic              unused_wbits;

   assign unused_wbits = ^bus_wdata[30:16];

   assign wr_cfg  = bus_we && (bus_addr == A_CFG);
   assign wr_cmd  = bus_we && (bus_addr == A_CMD);
   assign wr_adr  = bus_we && (bus_addr == A_ADR);
   assign wr_wdat = bus_we && (bus_addr == A_WDAT);

   assign abort = soft_q || (wr_cfg && bus_wdata[31]);
   assign rd_go = wr_cmd && bus_wdata[0] && !busy && !soft_q;
   assign wr_go = wr_wdat && !busy && !soft_q;
   assign start = rd_go || wr_go;
   assign code  = code_q;

   always_comb begin
      req.rd    = rd_go;
      req.phy   = phy_q;
      req.regn  = regn_q;
      req.wdata = bus_wdata[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_q <= 1'b0;
         code_q <= '0;
         cmd_q  <= 1'b0;
         phy_q  <= '0;
         regn_q <= '0;
         wdat_q <= '0;
         rdat_q <= '0;
         inv_q  <= 1'b0;
      end else begin
         if (wr_cfg) begin
            soft_q <= bus_wdata[31];
            code_q <= bus_wdata[CODE_W-1:0];
         end
         if (wr_cmd)
            cmd_q <= bus_wdata[0];
         if (wr_adr) begin
            phy_q  <= bus_wdata[8 +: PHY_W];
            regn_q <= bus_wdata[REG_W-1:0];
         end
         if (wr_go)
            wdat_q <= bus_wdata[DATA_W-1:0];
         if (rd_fin)
            rdat_q <= rd_data;
         if (abort)
            inv_q <= 1'b0;
         else if (rd_go)
            inv_q <= 1'b1;
         else if (rd_fin)
            inv_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CFG:  bus_rdata = {soft_q, {(31-CODE_W){1'b0}}, code_q};
         A_CMD:  bus_rdata = {31'b0, cmd_q};
         A_ADR:  bus_rdata = {19'b0, phy_q, 3'b0, regn_q};
         A_WDAT: bus_rdata = {16'b0, wdat_q};
         A_RDAT: bus_rdata = {16'b0, rdat_q};
         A_IND:  bus_rdata = {29'b0, inv_q, 1'b0, busy};
         default: bus_rdata = '0;
      endcase
   end

   assert_busy_keeps_wdat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_wdat) |=> $stable(wdat_q));

   assert_read_marks_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go |=> inv_q);

   assert_soft_blocks_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_q |-> !start);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
   import mdio_mgmt_pkg::*;
#(
   parameter int PRE_LEN    = 32,
   parameter int ADDR_W     = 8,
   parameter int CODE_W     = 4,
   parameter int FIXED_HALF = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);

   localparam int HALF_TOP = (FIXED_HALF > HALF_MAX) ? FIXED_HALF : HALF_MAX;
   localparam int CNT_W    = $clog2(HALF_TOP + 1);

   generate
      if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
         $error("mdio_mgmt_ctrl: PRE_LEN out of range");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("mdio_mgmt_ctrl: ADDR_W too narrow for the register map");
      end
      if (CODE_W < 4 || CODE_W > 16) begin : g_bad_code
         $error("mdio_mgmt_ctrl: CODE_W must lie in 4..16");
      end
      if (FIXED_HALF < 0) begin : g_bad_fixed
         $error("mdio_mgmt_ctrl: FIXED_HALF must not be negative");
      end
   endgenerate

   logic              busy;
   logic              start;
   logic              abort;
   logic              rd_fin;
   logic [DATA_W-1:0] rd_data;
   logic [CODE_W-1:0] code;
   logic [CNT_W-1:0]  half_lim;
   mdio_req_t         req;

   mdio_mgmt_regs #(
      .ADDR_W (ADDR_W),
      .CODE_W (CODE_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .busy      (busy),
      .rd_fin    (rd_fin),
      .rd_data   (rd_data),
      .start     (start),
      .req       (req),
      .abort     (abort),
      .code      (code)
   );

   mdio_mgmt_divsel #(
      .CODE_W     (CODE_W),
      .CNT_W      (CNT_W),
      .FIXED_HALF (FIXED_HALF)
   ) u_divsel (
      .code     (code),
      .half_lim (half_lim)
   );

   mdio_mgmt_frame #(
      .PRE_LEN (PRE_LEN),
      .CNT_W   (CNT_W)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .req      (req),
      .half_lim (half_lim),
      .abort    (abort),
      .mdio_i   (mdio_i),
      .busy     (busy),
      .mdc      (mdc),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .rd_fin   (rd_fin),
      .rd_data  (rd_data)
   );

endmodule

// File: tb/mdio_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_bench;

   localparam int A_CFG = 'h20, A_CMD = 'h24, A_ADR = 'h28;
   localparam int A_WD  = 'h2C, A_RD  = 'h30, A_IND = 'h34;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_we;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // reference model state
   logic        m_soft;
   logic [3:0]  m_div;
   logic        m_cmd;
   logic [4:0]  m_phy, m_reg;
   logic [15:0] m_wdat, m_rdat;
   logic        m_inv, m_busy, m_rd;
   int          m_start, m_h;
   logic [63:0] m_frame;
   logic [15:0] m_resp;
   logic [15:0] phy_resp;

   always #10 clk = ~clk;

   mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .mdc       (mdc),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe),
      .mdio_i    (mdio_i)
   );

   function automatic int half_of(input logic [3:0] c);
      case (c)
         4'd4: return 10;
         4'd5: return 14;
         4'd7: return 20;
         4'd9: return 28;
         default: return 28;
      endcase
   endfunction

   function automatic logic [31:0] model_rdata(input logic [7:0] a);
      case (int'(a))
         A_CFG: return {m_soft, 27'b0, m_div};
         A_CMD: return {31'b0, m_cmd};
         A_ADR: return {19'b0, m_phy, 3'b0, m_reg};
         A_WD:  return {16'b0, m_wdat};
         A_RD:  return {16'b0, m_rdat};
         A_IND: return {29'b0, m_inv, 1'b0, m_busy};
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h at cycle %0d", tag, what, act, exp, cyc);
      end
   endtask

   task automatic model_start(input logic rd, input logic [15:0] d);
      m_busy  = 1'b1;
      m_rd    = rd;
      m_start = cyc;
      m_h     = half_of(m_div);
      m_resp  = phy_resp;
      if (rd)
         m_frame = {32'hFFFF_FFFF, 2'b01, 2'b10, m_phy, m_reg, 18'h3FFFF};
      else
         m_frame = {32'hFFFF_FFFF, 2'b01, 2'b01, m_phy, m_reg, 2'b10, d};
   endtask

   // model update at every rising edge
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (!rst_n) begin
            m_soft = 0; m_div = 0; m_cmd = 0; m_phy = 0; m_reg = 0;
            m_wdat = 0; m_rdat = 0; m_inv = 0; m_busy = 0; m_rd = 0;
            m_start = 0; m_h = 28; m_frame = '0; m_resp = '0;
         end else begin
            automatic logic old_busy = m_busy;
            automatic logic old_soft = m_soft;
            automatic logic done = m_busy && ((cyc - m_start) == 128 * m_h);
            if (bus_we) begin
               case (int'(bus_addr))
                  A_CFG: begin
                     m_soft = bus_wdata[31];
                     m_div  = bus_wdata[3:0];
                     if (bus_wdata[31]) begin
                        m_busy = 0; m_inv = 0; done = 0;
                     end
                  end
                  A_CMD: begin
                     m_cmd = bus_wdata[0];
                     if (bus_wdata[0] && !old_busy && !old_soft) begin
                        model_start(1'b1, 16'h0);
                        m_inv = 1'b1;
                     end
                  end
                  A_ADR: begin
                     m_phy = bus_wdata[12:8];
                     m_reg = bus_wdata[4:0];
                  end
                  A_WD: begin
                     if (!old_busy && !old_soft) begin
                        m_wdat = bus_wdata[15:0];
                        model_start(1'b0, bus_wdata[15:0]);
                     end
                  end
                  default: ;
               endcase
            end
            if (done) begin
               m_busy = 0;
               if (m_rd) begin
                  m_rdat = m_resp;
                  m_inv  = 0;
               end
            end
         end
      end
   end

   // per-cycle comparison and PHY response, away from the rising edge
   initial begin
      mdio_i = 1'b1;
      forever begin
         @(negedge clk);
         #2;
         if (rst_n) begin
            automatic int e    = cyc - m_start;
            automatic int bitn = m_busy ? e / (2 * m_h) : 0;
            automatic logic x_mdc = m_busy ? (((e / m_h) % 2) == 1) : 1'b0;
            automatic logic x_oe  = m_busy ? (m_rd ? (bitn < 46) : 1'b1) : 1'b0;
            chk("R4", "mdc", {31'b0, mdc}, {31'b0, x_mdc});
            chk(m_busy ? (m_rd ? "R3" : "R2") : "R11", "mdio_oe", {31'b0, mdio_oe}, {31'b0, x_oe});
            if (x_oe)
               chk((bitn >= 36 && bitn <= 45) ? "R9" : (m_rd ? "R3" : "R2"),
                   "mdio_o", {31'b0, mdio_o}, {31'b0, m_frame[63 - bitn]});
            chk("R1", "bus_rdata", bus_rdata, model_rdata(bus_addr));
         end
         #1;
         if (m_busy && m_rd) begin
            automatic int b = (cyc - m_start) / (2 * m_h);
            mdio_i = (b >= 48) ? m_resp[15 - (b - 48)] : 1'b1;
         end else begin
            mdio_i = 1'b1;
         end
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = 8'(a);
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
      bus_addr  = 8'(A_IND);
   endtask

   task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_addr = 8'(a);
      #3;
      chk(tag, "register read", bus_rdata, exp);
   endtask

   task automatic wait_idle(output int n);
      bus_addr = 8'(A_IND);
      n = 0;
      #3;
      while (bus_rdata[0]) begin
         n++;
         @(negedge clk);
         #3;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R6 watchdog actual hung expected idle at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      rst_n = 1'b0; bus_we = 1'b0; bus_addr = 8'h0; bus_wdata = 32'h0; phy_resp = 16'h0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values, R11 idle pins
      rd_chk(A_CFG, 32'h0, "R1");
      rd_chk(A_CMD, 32'h0, "R1");
      rd_chk(A_ADR, 32'h0, "R1");
      rd_chk(A_WD,  32'h0, "R1");
      rd_chk(A_RD,  32'h0, "R1");
      rd_chk(A_IND, 32'h0, "R1");
      chk("R11", "idle mdc/oe", {30'b0, mdc, mdio_oe}, 32'h0);

      // R2 write frame, code 4
      wr(A_ADR, 32'hFFFF_E51A);
      wr(A_CFG, 32'h0000_0004);
      rd_chk(A_CFG, 32'h4, "R1");
      rd_chk(A_ADR, 32'h051A, "R1");
      wr(A_WD, 32'hFFFF_A5C3);
      wait_idle(n);
      chk("R6", "write frame busy cycles", n, 128 * 10);
      rd_chk(A_WD, 32'h0000_A5C3, "R2");

      // R8 / R9 interference during a frame
      wr(A_WD, 32'h0000_3C0F);
      repeat (100) @(negedge clk);
      wr(A_ADR, 32'h0000_1F1F);
      wr(A_WD, 32'h0000_1234);
      wr(A_CMD, 32'h1);
      rd_chk(A_IND, 32'h1, "R8");
      wait_idle(n);
      rd_chk(A_WD, 32'h0000_3C0F, "R8");
      rd_chk(A_IND, 32'h0, "R8");
      rd_chk(A_ADR, 32'h1F1F, "R9");
      wr(A_CMD, 32'h0);

      // R3 / R7 read frame, code 5
      phy_resp = 16'h8001;
      wr(A_CFG, 32'h5);
      wr(A_ADR, 32'h0000_1F00);
      wr(A_CMD, 32'h1);
      rd_chk(A_IND, 32'h5, "R7");
      wait_idle(n);
      chk("R5", "code 5 busy cycles", n, 128 * 14 - 1);
      rd_chk(A_RD, 32'h8001, "R3");
      rd_chk(A_IND, 32'h0, "R7");
      wr(A_CMD, 32'h0);

      // code 7, write frame must not mark data invalid
      wr(A_CFG, 32'h7);
      wr(A_ADR, 32'h0000_001F);
      wr(A_WD, 32'h0000_FFFF);
      rd_chk(A_IND, 32'h1, "R7");
      wait_idle(n);
      chk("R5", "code 7 busy cycles", n, 128 * 20 - 1);
      rd_chk(A_RD, 32'h8001, "R7");

      // code 9 read
      phy_resp = 16'h3C5A;
      wr(A_CFG, 32'h9);
      wr(A_ADR, 32'h0000_0A15);
      wr(A_CMD, 32'h1);
      wait_idle(n);
      chk("R5", "code 9 busy cycles", n, 128 * 28);
      rd_chk(A_RD, 32'h3C5A, "R3");
      wr(A_CMD, 32'h0);

      // unlisted code falls back to 28
      wr(A_CFG, 32'h2);
      wr(A_WD, 32'h0000_0F0F);
      wait_idle(n);
      chk("R5", "code 2 busy cycles", n, 128 * 28);

      // R10 soft reset during a read
      phy_resp = 16'hFFFF;
      wr(A_CFG, 32'h4);
      wr(A_CMD, 32'h1);
      repeat (300) @(negedge clk);
      wr(A_CFG, 32'h8000_0004);
      #3;
      chk("R10", "indicator after abort", bus_rdata, 32'h0);
      chk("R10", "mdc/oe after abort", {30'b0, mdc, mdio_oe}, 32'h0);
      wr(A_CMD, 32'h0);
      wr(A_WD, 32'h0000_5555);
      rd_chk(A_IND, 32'h0, "R10");
      rd_chk(A_WD, 32'h0000_0F0F, "R10");
      rd_chk(A_RD, 32'h3C5A, "R10");
      rd_chk(A_CFG, 32'h8000_0004, "R10");
      wr(A_CFG, 32'h4);
      wr(A_WD, 32'h0000_5555);
      wait_idle(n);
      chk("R10", "frame after soft reset release", n, 128 * 10);

      repeat (5) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule